// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects interrupt events from a peripheral into a vector of pending cause bits and gates them with a vector of enable bits. It drives a single level-sensitive interrupt line. Hardware raises causes with one-cycle pulses on a per-bit event vector. Software reaches the unit through a single-cycle register port with four word addresses.

Reading the cause register returns the pending causes and clears them in the same access. Software can post an interrupt of its own through a separate write-ones-to-set register. Enables are changed through a write-ones-to-set register and a write-ones-to-clear register, so no read-modify-write sequence is needed and concurrent agents do not overwrite each other's changes.

Top module: `irq_cause_unit`

## Requirements
- R1: After an active-low reset, every cause bit and every mask bit is 0 and `irq_o` is 0.
- R2: A read at address 0 returns the pending cause vector in the same cycle, and every bit that was set at that read is cleared at the next clock edge.
- R3: A cause bit whose hardware event pulse arrives in the same cycle as a clearing read at address 0 is set after that edge.
- R4: A write at address 1 sets every cause bit whose data bit is 1. Cause bits whose data bit is 0 keep their value.
- R5: A hardware event sets its cause bit whatever the value of the matching mask bit.
- R6: A write at address 2 sets every mask bit whose data bit is 1. A write at address 3 clears every mask bit whose data bit is 1. In both cases mask bits whose data bit is 0 keep their value.
- R7: A read at address 2 returns the current mask vector in the same cycle.
- R8: `irq_o` is registered. After each clock edge it equals the OR over all positions of cause AND mask, as those values stood before that edge.
- R9: Reads at addresses 1 and 3 return 0 and change no state. Writes at address 0 are ignored.
- R10: `rd_data_o` is 0 in every cycle where `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_evt_i | input | NUM_SRC | One-cycle event pulses, one per cause bit |
| addr_i | input | 2 | Register address: 0 cause read, 1 cause set, 2 mask set/read, 3 mask clear |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_SRC | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | NUM_SRC | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can land on the same cause bit in one cycle: the clear caused by a software read, and a set caused by either a hardware pulse or a software posting write. Directed steps issue a clearing read together with an event pulse on the same bit. A later read must then show that bit set. Random steps draw event vectors, addresses, strobes and data together, so reads, set-writes and events overlap many times. Every read value and every `irq_o` level is compared against a bench model that applies "set wins over read-clear".

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_CAUSE_RD  = 2'd0,
    REG_CAUSE_SET = 2'd1,
    REG_MASK_SET  = 2'd2,
    REG_MASK_CLR  = 2'd3
  } irq_reg_e;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hw_evt_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic               rd_clr_i,
  output logic [NUM_SRC-1:0] cause_o
);
  logic [NUM_SRC-1:0] cause_q, keep;

  // set sources take priority over the read-clear
  assign keep = rd_clr_i ? '0 : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= keep | hw_evt_i | sw_set_i;

  assign cause_o = cause_q;

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && hw_evt_i == '0 && sw_set_i == '0) |=> cause_q == '0); // R2
  AST_EVT_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cause_q & $past(hw_evt_i)) == $past(hw_evt_i)); // R3
  AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cause_q & $past(sw_set_i)) == $past(sw_set_i)); // R4
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && hw_evt_i == '0 && sw_set_i == '0) |=> $stable(cause_q)); // R9
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;

  assign mask_o = mask_q;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> (mask_q & $past(set_i)) == $past(set_i)); // R6
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mask_q & $past(clr_i)) == '0); // R6
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cause_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause_i & mask_i);

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hw_evt_i,
  input  logic [1:0]         addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  input  logic               rd_en_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o
);
  irq_reg_e           reg_sel;
  logic [NUM_SRC-1:0] cause, mask, sw_set, m_set, m_clr;
  logic               rd_clr;

  assign reg_sel = irq_reg_e'(addr_i);
  assign rd_clr  = rd_en_i && reg_sel == REG_CAUSE_RD;
  assign sw_set  = (wr_en_i && reg_sel == REG_CAUSE_SET) ? wr_data_i : '0;
  assign m_set   = (wr_en_i && reg_sel == REG_MASK_SET)  ? wr_data_i : '0;
  assign m_clr   = (wr_en_i && reg_sel == REG_MASK_CLR)  ? wr_data_i : '0;

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (reg_sel)
        REG_CAUSE_RD: rd_data_o = cause;
        REG_MASK_SET: rd_data_o = mask;
        default:      rd_data_o = '0;
      endcase
    end
  end

  irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk_i, .rst_ni, .hw_evt_i, .sw_set_i(sw_set), .rd_clr_i(rd_clr), .cause_o(cause)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i, .rst_ni, .set_i(m_set), .clr_i(m_clr), .mask_o(mask)
  );

  irq_line #(.NUM_SRC(NUM_SRC)) u_line (
    .clk_i, .rst_ni, .cause_i(cause), .mask_i(mask), .irq_o
  );

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((cause & mask) != '0)); // R8
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past((cause & mask) == '0)); // R8
  AST_EVT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0 && hw_evt_i != '0) |=> cause != '0); // R5
endmodule

// File: tb/irq_cause_unit_test.sv
`timescale 1ns/1ps
module irq_cause_unit_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic [1:0]   addr = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [N-1:0] wd = '0;
  logic [N-1:0] rd;
  logic         irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] cause_m = '0, mask_m = '0;
  logic         irq_m = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_unit #(.NUM_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hw_evt_i(evt), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wd), .rd_en_i(re), .rd_data_o(rd), .irq_o(irq)
  );

  function automatic logic [N-1:0] exp_rd(logic r, logic [1:0] a, logic [N-1:0] c, logic [N-1:0] m);
    if (!r) return '0;
    case (a)
      2'd0:    return c;
      2'd2:    return m;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] a, logic w, logic r, logic [N-1:0] d, logic [N-1:0] e);
    logic [N-1:0] cn, mn;
    @(negedge clk);
    addr = a; we = w; re = r; wd = d; evt = e;
    #1;
    check(r ? tag : "R10", rd, exp_rd(r, a, cause_m, mask_m));
    cn = ((r && a == 2'd0) ? '0 : cause_m) | e | ((w && a == 2'd1) ? d : '0);
    mn = mask_m;
    if (w && a == 2'd2) mn = mn | d;
    if (w && a == 2'd3) mn = mn & ~d;
    irq_m = |(cause_m & mask_m);
    @(posedge clk);
    cause_m = cn; mask_m = mn;
    #1;
    check("R8", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, irq_m});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    // R1 reset state
    #1 check("R1", {{(N-1){1'b0}}, irq}, '0);
    step("R1", 2'd0, 0, 1, '0, '0);
    step("R1", 2'd2, 0, 1, '0, '0);
    // R5 event with mask off still latches
    step("R5", 2'd0, 0, 0, '0, 16'h0010);
    step("R5", 2'd0, 0, 1, '0, '0);
    step("R2", 2'd0, 0, 1, '0, '0);
    // R4 software post, zeros keep
    step("R4", 2'd1, 1, 0, 16'h0101, '0);
    step("R4", 2'd1, 1, 0, 16'h0002, '0);
    step("R4", 2'd0, 0, 1, '0, '0);
    // R3 event during clearing read survives
    step("R3", 2'd1, 1, 0, 16'h00F0, '0);
    step("R3", 2'd0, 0, 1, '0, 16'h0020);
    step("R3", 2'd0, 0, 1, '0, '0);
    // R6/R7 mask set and clear
    step("R6", 2'd2, 1, 0, 16'hFF00, '0);
    step("R6", 2'd3, 1, 0, 16'h0F00, '0);
    step("R6", 2'd2, 1, 0, 16'h0001, '0);
    step("R7", 2'd2, 0, 1, '0, '0);
    // R8 irq rise and fall
    step("R8", 2'd0, 0, 0, '0, 16'h0001);
    step("R8", 2'd0, 0, 0, '0, '0);
    step("R8", 2'd0, 0, 1, '0, '0);
    step("R8", 2'd0, 0, 0, '0, '0);
    // R9 side-effect-free reads and ignored writes
    step("R9", 2'd1, 0, 0, 16'h8000, 16'h8000);
    step("R9", 2'd1, 0, 1, '0, '0);
    step("R9", 2'd3, 0, 1, '0, '0);
    step("R9", 2'd0, 1, 0, 16'hFFFF, '0);
    step("R9", 2'd2, 0, 1, '0, '0);
    step("R9", 2'd0, 0, 1, '0, '0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic [N-1:0] e;
      a = 2'($urandom);
      e = ($urandom_range(3) == 0) ? N'($urandom) & N'($urandom) : '0;
      step(a == 2'd0 ? "R2" : (a == 2'd2 ? "R7" : "R9"), a, 1'($urandom),
           1'($urandom), N'($urandom), e);
    end
    @(negedge clk);
    we = 0; re = 0; evt = '0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule